// File: doc/BRIEF.md
# Interrupt control and flag register

This block is an eight-bit interrupt control register with sticky event flags and one combined interrupt request to the processor core. It takes four kinds of input. Timer overflow and external pin events arrive as one-cycle pulses. Interrupt-on-change events arrive as a per-bit pulse vector. A peripheral request arrives as a level. Software reads the whole register through a register port and writes its writable bits there.

A flag is captured whatever the enable bits hold, so software can poll a source with its interrupt masked. Software should clear a stale flag before it enables that source. The change flag cannot be written. It is the OR of a separate change-flag vector that the block holds, and software clears that vector bit by bit through its own write port. The request output is the global enable ANDed with the OR of the enabled sources.

Top module: `intr_ctl_reg`

## Requirements
- R1: After reset every register bit reads 0, the change-flag vector reads 0, and `irq` is 0.
- R2: The register layout is bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 external enable, bit 3 change enable, bit 2 timer flag, bit 1 external flag, bit 0 change flag. A write to bits 7..3 reads back from the next cycle on.
- R3: A pulse on `tmr_ovf_pulse` sets bit 2, and a pulse on `ext_pulse` sets bit 1, from the cycle after the pulse. This happens whatever the enable bits hold.
- R4: Bits 2 and 1 stay set until a register write puts 0 in them. A write of 1 sets them.
- R5: If a flag-setting pulse and a register write of 0 to the same flag fall in one cycle, the flag ends set.
- R6: Bit 0 reads 1 exactly while any bit of the change-flag vector is 1. Register writes to bit 0 have no effect.
- R7: A `chg_evt` bit sets the matching change-flag bit on the next cycle. A vector write with `chg_wdata` bit 0 clears that bit, and bit 1 leaves it alone. A set in the same cycle wins over a clear.
- R8: `irq` is bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)), combinationally in the same cycle.
- R9: While bit 7 is 0, `irq` is 0 whatever the flags and the peripheral request hold.
- R10: Reading has no side effects. With no write and no event, all register bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_pulse | input | 1 | Timer overflow event pulse |
| ext_pulse | input | 1 | External pin event pulse |
| chg_evt | input | CHG_W | Per-bit change event pulses |
| chg_wr_en | input | 1 | Change-flag vector write strobe |
| chg_wdata | input | CHG_W | Vector write data; a 0 bit clears that flag |
| chg_flags | output | CHG_W | Current change-flag vector |
| periph_req | input | 1 | Combined peripheral request level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| irq | output | 1 | Interrupt request to the core |

## Verification
Flag and enable changes appear on `reg_rdata` and `chg_flags` one clock edge after the pulse or write that causes them. `irq` follows the registered bits and `periph_req` with no added delay. The bench drives every input on the falling edge. It samples 2 ns after the next rising edge, so the state seen already includes that edge's update. A behavioural model advances on the same rising edge and is compared on every cycle. Directed checks with literal expected values cover the same-cycle set-versus-clear collisions and the ignored bit-0 write.

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg #(
  parameter int CHG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_ovf_pulse,
  input  logic             ext_pulse,
  input  logic [CHG_W-1:0] chg_evt,
  input  logic             chg_wr_en,
  input  logic [CHG_W-1:0] chg_wdata,
  output logic [CHG_W-1:0] chg_flags,
  input  logic             periph_req,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  localparam int B_GLB = 7;
  localparam int B_PER = 6;
  localparam int B_TEN = 5;
  localparam int B_XEN = 4;
  localparam int B_CEN = 3;
  localparam int B_TFL = 2;
  localparam int B_XFL = 1;
  localparam int B_CFL = 0;

  logic glb_q, per_q, ten_q, xen_q, cen_q;
  logic tfl_q, xfl_q;
  logic [CHG_W-1:0] chg_q;
  logic chg_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      per_q <= 1'b0;
      ten_q <= 1'b0;
      xen_q <= 1'b0;
      cen_q <= 1'b0;
    end else if (reg_wr_en) begin
      glb_q <= reg_wdata[B_GLB];
      per_q <= reg_wdata[B_PER];
      ten_q <= reg_wdata[B_TEN];
      xen_q <= reg_wdata[B_XEN];
      cen_q <= reg_wdata[B_CEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tfl_q <= 1'b0;
      xfl_q <= 1'b0;
    end else begin
      tfl_q <= tmr_ovf_pulse | (reg_wr_en ? reg_wdata[B_TFL] : tfl_q);
      xfl_q <= ext_pulse     | (reg_wr_en ? reg_wdata[B_XFL] : xfl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_evt | (chg_wr_en ? (chg_q & chg_wdata) : chg_q);
  end

  assign chg_any   = |chg_q;
  assign chg_flags = chg_q;

  assign reg_rdata[B_GLB] = glb_q;
  assign reg_rdata[B_PER] = per_q;
  assign reg_rdata[B_TEN] = ten_q;
  assign reg_rdata[B_XEN] = xen_q;
  assign reg_rdata[B_CEN] = cen_q;
  assign reg_rdata[B_TFL] = tfl_q;
  assign reg_rdata[B_XFL] = xfl_q;
  assign reg_rdata[B_CFL] = chg_any;

  assign irq = glb_q & ((ten_q & tfl_q) | (xen_q & xfl_q) |
                        (cen_q & chg_any) | (per_q & periph_req));

  p_tmr_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_pulse |=> reg_rdata[B_TFL]);
  p_ext_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> reg_rdata[B_XFL]);
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && reg_rdata[B_TFL]) |=> reg_rdata[B_TFL]);
  p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pulse && reg_wr_en && !reg_wdata[B_XFL]) |=> reg_rdata[B_XFL]);
  p_wr_bit0_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[B_CFL] && !(|chg_evt) && !chg_wr_en && !reg_rdata[B_CFL])
      |=> !reg_rdata[B_CFL]);
  p_chg_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg_evt) |=> (reg_rdata[B_CFL] && (chg_flags != '0)));
  p_glb_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[B_GLB] |-> !irq);
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !tmr_ovf_pulse && !ext_pulse && !chg_wr_en && !(|chg_evt))
      |=> $stable(reg_rdata));
endmodule

// File: tb/intr_ctl_reg_test.sv
module intr_ctl_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_ovf_pulse = 1'b0, ext_pulse = 1'b0, chg_wr_en = 1'b0;
  logic periph_req = 1'b0, reg_wr_en = 1'b0;
  logic [7:0] chg_evt = '0, chg_wdata = '0, reg_wdata = '0;
  logic [7:0] chg_flags, reg_rdata;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_ctl_reg #(.CHG_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_pulse(tmr_ovf_pulse), .ext_pulse(ext_pulse),
    .chg_evt(chg_evt), .chg_wr_en(chg_wr_en), .chg_wdata(chg_wdata),
    .chg_flags(chg_flags), .periph_req(periph_req), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // behavioural reference
  bit m_en[5];
  bit m_tf, m_xf;
  bit [7:0] m_chg;

  function automatic bit [7:0] m_reg();
    return {m_en[4], m_en[3], m_en[2], m_en[1], m_en[0], m_tf, m_xf, (m_chg != 0)};
  endfunction

  function automatic bit m_irq();
    bit [7:0] r = m_reg();
    return r[7] && ((r[5] && r[2]) || (r[4] && r[1]) || (r[3] && r[0]) || (r[6] && periph_req));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_en[i] = 0;
      m_tf = 0; m_xf = 0; m_chg = 0;
    end else begin
      bit [7:0] nc;
      nc = m_chg;
      if (chg_wr_en) for (int i = 0; i < 8; i++) if (!chg_wdata[i]) nc[i] = 0;
      nc = nc | chg_evt;
      m_chg = nc;
      if (reg_wr_en) begin
        for (int i = 0; i < 5; i++) m_en[i] = reg_wdata[i+3];
        m_tf = reg_wdata[2];
        m_xf = reg_wdata[1];
      end
      if (tmr_ovf_pulse) m_tf = 1;
      if (ext_pulse) m_xf = 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("R2 model reg", {24'd0, reg_rdata}, {24'd0, m_reg()});
      check("R7 model vector", {24'd0, chg_flags}, {24'd0, m_chg});
      check("R8 model irq", {31'd0, irq}, {31'd0, m_irq()});
    end
  end

  task automatic cyc(bit tm, bit ex, bit [7:0] ce, bit cw, bit [7:0] cwd, bit rw, bit [7:0] rwd);
    @(negedge clk);
    tmr_ovf_pulse = tm; ext_pulse = ex; chg_evt = ce; chg_wr_en = cw;
    chg_wdata = cwd; reg_wr_en = rw; reg_wdata = rwd;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 0, 8'h00, 0, 8'h00);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset reg", {24'd0, reg_rdata}, 32'h00);
    check("R1 reset vector", {24'd0, chg_flags}, 32'h00);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1;
    idle();
    // R2 / R6: enables read back, bit0 write ignored
    cyc(0, 0, 0, 0, 0, 1, 8'hF9);
    check("R2 enables readback", {24'd0, reg_rdata}, 32'hF8);
    check("R6 bit0 write ignored", {31'd0, reg_rdata[0]}, 32'd0);
    check("R8 no source no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); periph_req = 1; #1;
    check("R8 peripheral irq", {31'd0, irq}, 32'd1);
    cyc(0, 0, 0, 0, 0, 1, 8'hB8);
    check("R8 peripheral masked", {31'd0, irq}, 32'd0);
    // R9
    cyc(0, 0, 0, 0, 0, 1, 8'h78);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check("R3 timer flag", {24'd0, reg_rdata}, 32'h7C);
    check("R9 global off quiet", {31'd0, irq}, 32'd0);
    @(negedge clk); periph_req = 0;
    // R3 with all enables off
    cyc(0, 0, 0, 0, 0, 1, 8'h00);
    cyc(0, 1, 0, 0, 0, 0, 0);
    check("R3 ext flag enables off", {24'd0, reg_rdata}, 32'h02);
    // R4 sticky, R10 stable
    idle(); idle(); idle();
    check("R4 sticky flag", {24'd0, reg_rdata}, 32'h02);
    check("R10 idle stable", {24'd0, reg_rdata}, 32'h02);
    cyc(0, 0, 0, 0, 0, 1, 8'h00);
    check("R4 software clear", {24'd0, reg_rdata}, 32'h00);
    cyc(0, 0, 0, 0, 0, 1, 8'h06);
    check("R4 software set", {24'd0, reg_rdata}, 32'h06);
    // R5 collision
    cyc(1, 0, 0, 0, 0, 1, 8'h00);
    check("R5 timer set wins", {24'd0, reg_rdata}, 32'h04);
    cyc(0, 1, 0, 0, 0, 1, 8'h00);
    check("R5 ext set wins", {24'd0, reg_rdata}, 32'h02);
    cyc(0, 0, 0, 0, 0, 1, 8'h00);
    // R6 / R7 change vector
    cyc(0, 0, 8'h21, 0, 0, 0, 0);
    check("R7 vector set", {24'd0, chg_flags}, 32'h21);
    check("R6 change flag set", {24'd0, reg_rdata}, 32'h01);
    cyc(0, 0, 0, 0, 0, 1, 8'h00);
    check("R6 write cannot clear", {24'd0, reg_rdata}, 32'h01);
    cyc(0, 0, 0, 1, 8'hDF, 0, 0);
    check("R7 partial clear", {24'd0, chg_flags}, 32'h01);
    check("R6 still set", {31'd0, reg_rdata[0]}, 32'd1);
    cyc(0, 0, 8'h01, 1, 8'hFE, 0, 0);
    check("R7 set beats clear", {24'd0, chg_flags}, 32'h01);
    cyc(0, 0, 0, 1, 8'h00, 0, 0);
    check("R7 full clear", {24'd0, chg_flags}, 32'h00);
    check("R6 flag clears", {31'd0, reg_rdata[0]}, 32'd0);
    // R8 change source
    cyc(0, 0, 0, 0, 0, 1, 8'h88);
    check("R8 no flag no irq", {31'd0, irq}, 32'd0);
    cyc(0, 0, 8'h80, 0, 0, 0, 0);
    check("R8 change irq", {31'd0, irq}, 32'd1);
    cyc(0, 0, 0, 0, 0, 1, 8'hA0);
    check("R8 timer enabled no flag", {31'd0, irq}, 32'd0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check("R8 timer irq", {31'd0, irq}, 32'd1);
    idle(); idle();
    check("R10 reads no side effect", {24'd0, reg_rdata}, 32'hA5);
    finish_run();
  end
endmodule